// File: doc/BRIEF.md
# Up/Down Timer with Clear Controls

This block is a 16-bit counter fed by an 8-bit prescaler, and it is driven through an 8-bit control register. The counter runs only while the local enable bit and the global enable input are both high. It counts up or down. The direction comes from a hardware select pair of inputs when that pair is marked valid; otherwise a software bit sets it. Two capture channels copy the counter value when a trigger arrives. A load trigger writes a preset value into the counter. A compare value is matched against the counter on every prescaler tick.

Options in the control register clear the counter and reload the prescaler when a capture or a compare match occurs. A self-clearing bit clears the counter without raising an interrupt. The read-only fields report the direction in use, whether the counter is running, and whether the counter wrapped between two captures on channel 0. Capture and load act even while the counter is stopped. An interrupt-request pulse reports wraps, compare matches and captures.

Top module: `updn_timer`

## Requirements
- R1: After reset the control register reads 00h, the counter and both capture registers read 0000h, and `irq` and `ovf_pulse` are low.
- R2: The counter changes on its own only while control bit 7 (enable) and `glb_en` are both 1. While either is 0, counter and prescaler hold their values. When counting resumes it continues from the held values, with no reload.
- R3: With prescaler divisor N on `psc_div`, the counter steps once every N+1 clocks while running. A prescaler reload sets the prescaler back to N.
- R4: When `dir_hw_valid` is 1, `dir_hw_up` sets the direction; otherwise control bit 3 sets it (1 = up, 0 = down). Read-only bit 2 shows the direction in use (1 = up).
- R5: Counting up from FFFFh gives 0000h, and counting down from 0000h gives FFFFh. Each wrap makes `ovf_pulse` high for one cycle, on the cycle in which the wrapped value appears.
- R6: When control bit 6 is 1, a trigger on either capture channel clears the counter to 0 and reloads the prescaler. The clear has priority over load and count.
- R7: When control bit 5 is 1, a tick that finds the counter equal to `cmp_val` clears the counter to 0 instead of stepping it and reloads the prescaler.
- R8: Writing 1 to control bit 4 clears the counter on the next edge and raises no interrupt. Bit 4 always reads back 0.
- R9: Read-only bit 1 is updated at each channel-0 capture. It becomes 1 if a wrap occurred since the previous channel-0 capture (the current cycle included), and 0 otherwise.
- R10: `load_trig` writes `load_val` into the counter, and a capture trigger copies the current counter value into its register. Both work whether or not the counter is enabled.
- R11: Read-only bit 0 reads 1 while the counter is running (enable bit AND `glb_en`) and 0 while it is halted.
- R12: `irq` is high for one cycle after a cycle that contains a wrap, a compare match or a capture trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global count enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| dir_hw_valid | input | 1 | Hardware direction select is valid |
| dir_hw_up | input | 1 | Hardware direction (1 = up) |
| psc_div | input | 8 | Prescaler divisor N |
| load_trig | input | 1 | Load trigger |
| load_val | input | 16 | Value to load |
| cap0_trig | input | 1 | Capture channel 0 trigger |
| cap1_trig | input | 1 | Capture channel 1 trigger |
| cmp_val | input | 16 | Compare value |
| cnt_o | output | 16 | Counter value |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| ovf_pulse | output | 1 | Wrap pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong prescaler phase or a wrong direction choice shows up on `cnt_o` at the first tick after the fault, so comparing on every clock catches it within N+1 cycles. A stale wrap-seen flag appears only at the next channel-0 capture, in read-only bit 1, so the bench captures both just after a wrap and again with no wrap in between. Clear and load priorities show up in the very cycle they collide, so the bench sets up captures and compare matches that coincide with ticks.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam int CTL_W  = 8;
  localparam int B_EN   = 7;
  localparam int B_CCP  = 6;
  localparam int B_CCMP = 5;
  localparam int B_CLR  = 4;
  localparam int B_UDC  = 3;
  localparam int B_DIRS = 2;
  localparam int B_OF   = 1;
  localparam int B_RUN  = 0;
endpackage

// File: rtl/updn_timer_psc.sv
module updn_timer_psc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             reload,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (reload)
      pc_d = div;
    else if (run)
      pc_d = (pc_q == '0) ? div : pc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign tick = run & (pc_q == '0);
endmodule

// File: rtl/updn_timer_ctl.sv
module updn_timer_ctl
  import updn_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             glb_en,
  input  logic             hw_valid,
  input  logic             hw_up,
  input  logic             of0,
  output logic             ccp,
  output logic             ccmp,
  output logic             clr_pulse,
  output logic             dir_up,
  output logic             run,
  output logic [CTL_W-1:0] rdata
);
  logic en_q, ccp_q, ccmp_q, udc_q;
  logic en_d, ccp_d, ccmp_d, udc_d;

  always_comb begin
    en_d   = en_q;
    ccp_d  = ccp_q;
    ccmp_d = ccmp_q;
    udc_d  = udc_q;
    if (wr) begin
      en_d   = wdata[B_EN];
      ccp_d  = wdata[B_CCP];
      ccmp_d = wdata[B_CCMP];
      udc_d  = wdata[B_UDC];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ccp_q  <= 1'b0;
      ccmp_q <= 1'b0;
      udc_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      ccp_q  <= ccp_d;
      ccmp_q <= ccmp_d;
      udc_q  <= udc_d;
    end
  end

  assign clr_pulse = wr & wdata[B_CLR];
  assign dir_up    = hw_valid ? hw_up : udc_q;
  assign run       = en_q & glb_en;
  assign ccp       = ccp_q;
  assign ccmp      = ccmp_q;

  always_comb begin
    rdata         = '0;
    rdata[B_EN]   = en_q;
    rdata[B_CCP]  = ccp_q;
    rdata[B_CCMP] = ccmp_q;
    rdata[B_UDC]  = udc_q;
    rdata[B_DIRS] = dir_up;
    rdata[B_OF]   = of0;
    rdata[B_RUN]  = run;
  end
endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core #(
  parameter int CNT_W = 16,
  parameter int NCAP  = 2
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       tick,
  input  logic                       dir_up,
  input  logic                       sw_clr,
  input  logic                       ccp,
  input  logic                       ccmp,
  input  logic                       load,
  input  logic [CNT_W-1:0]           load_val,
  input  logic [NCAP-1:0]            cap_trig,
  input  logic [CNT_W-1:0]           cmp_val,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCAP-1:0][CNT_W-1:0] cap_q,
  output logic                       of0,
  output logic                       wrap,
  output logic                       cmp_hit,
  output logic                       psc_reload
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d, of0_q, of0_d;
  logic             cap_clr, cmp_clr, any_clr, at_end;

  always_comb begin
    cmp_hit    = tick & (cnt_q == cmp_val);
    cap_clr    = ccp & (|cap_trig);
    cmp_clr    = ccmp & cmp_hit;
    any_clr    = sw_clr | cap_clr | cmp_clr;
    psc_reload = cap_clr | cmp_clr;
    at_end     = dir_up ? (&cnt_q) : ~(|cnt_q);
    wrap       = tick & at_end & ~any_clr & ~load;

    if (any_clr)   cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (tick) cnt_d = dir_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    else           cnt_d = cnt_q;

    seen_d = seen_q | wrap;
    of0_d  = of0_q;
    if (cap_trig[0]) begin
      of0_d  = seen_q | wrap;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      of0_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      of0_q  <= of0_d;
    end
  end

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)          cap_q[g] <= '0;
      else if (cap_trig[g]) cap_q[g] <= cnt_q;
    end
  end

  assign cnt = cnt_q;
  assign of0 = of0_q;
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             dir_hw_valid,
  input  logic             dir_hw_up,
  input  logic [PSC_W-1:0] psc_div,
  input  logic             load_trig,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cap0_trig,
  input  logic             cap1_trig,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             ovf_pulse,
  output logic             irq
);
  localparam int NCAP = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic ccp, ccmp, clr_pulse, dir_up, run, of0, tick, wrap, cmp_hit, psc_reload;
  logic [NCAP-1:0]            cap_trig;
  logic [NCAP-1:0][CNT_W-1:0] cap_q;

  assign cap_trig = {cap1_trig, cap0_trig};

  updn_timer_ctl u_ctl (
    .clk(clk), .rst_ni(rst_ni), .wr(ctl_wr), .wdata(ctl_wdata), .glb_en(glb_en),
    .hw_valid(dir_hw_valid), .hw_up(dir_hw_up), .of0(of0), .ccp(ccp), .ccmp(ccmp),
    .clr_pulse(clr_pulse), .dir_up(dir_up), .run(run), .rdata(ctl_rdata)
  );

  updn_timer_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_ni(rst_ni), .run(run), .reload(psc_reload), .div(psc_div), .tick(tick)
  );

  updn_timer_core #(.CNT_W(CNT_W), .NCAP(NCAP)) u_core (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .dir_up(dir_up), .sw_clr(clr_pulse),
    .ccp(ccp), .ccmp(ccmp), .load(load_trig), .load_val(load_val), .cap_trig(cap_trig),
    .cmp_val(cmp_val), .cnt(cnt_o), .cap_q(cap_q), .of0(of0), .wrap(wrap),
    .cmp_hit(cmp_hit), .psc_reload(psc_reload)
  );

  assign cap0_o = cap_q[0];
  assign cap1_o = cap_q[1];

  logic ovf_d, irq_d, ovf_q, irq_q;
  assign ovf_d = wrap;
  assign irq_d = wrap | cmp_hit | (|cap_trig);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

  assign ovf_pulse = ovf_q;
  assign irq       = irq_q;
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [7:0]       ctl_wdata,
  input logic [7:0]       ctl_rdata,
  input logic             load_trig,
  input logic             cap0_trig,
  input logic             cap1_trig,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap0_o,
  input logic             ovf_pulse,
  input logic             irq
);
  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[0] && !load_trig && !cap0_trig && !cap1_trig && !ctl_wr) |=> $stable(cnt_o));

  assert_wrap_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_o == '0 || cnt_o == '1));

  assert_wrap_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> irq);

  assert_clear_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[4]) |=> (cnt_o == '0));

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap0_trig |=> (cap0_o == $past(cnt_o)));
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .load_trig(load_trig), .cap0_trig(cap0_trig), .cap1_trig(cap1_trig), .cnt_o(cnt_o),
  .cap0_o(cap0_o), .ovf_pulse(ovf_pulse), .irq(irq)
);

// File: tb/updn_timer_tb.sv
module updn_timer_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b1, ctl_wr = 1'b0, hwv = 1'b0, hwup = 1'b0;
  logic load_trig = 1'b0, cap0 = 1'b0, cap1 = 1'b0;
  logic [7:0]  wdata = 8'h00, div = 8'h00, rdata;
  logic [15:0] load_val = 16'h0, cmp_val = 16'h8000, cnt_o, cap0_o, cap1_o;
  logic ovf_pulse, irq;

  always #(PERIOD/2) clk = ~clk;

  updn_timer dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ctl_wr(ctl_wr), .ctl_wdata(wdata),
    .ctl_rdata(rdata), .dir_hw_valid(hwv), .dir_hw_up(hwup), .psc_div(div),
    .load_trig(load_trig), .load_val(load_val), .cap0_trig(cap0), .cap1_trig(cap1),
    .cmp_val(cmp_val), .cnt_o(cnt_o), .cap0_o(cap0_o), .cap1_o(cap1_o),
    .ovf_pulse(ovf_pulse), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_cnt = 0, m_c0 = 0, m_c1 = 0;
  int  m_psc = 0;
  bit  m_en = 0, m_ccp = 0, m_ccmp = 0, m_udc = 0, m_of0 = 0, m_seen = 0;
  bit  m_irq = 0, m_ovf = 0;
  bit  saw_ovf = 0;
  int  max_cnt = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    bit run = m_en && glb_en;
    bit dir = hwv ? hwup : m_udc;
    return {m_en, m_ccp, m_ccmp, 1'b0, m_udc, dir, m_of0, run};
  endfunction

  // one clock: model next state from current inputs, compare after the edge
  task automatic step();
    bit run = m_en && glb_en;
    bit dir = hwv ? hwup : m_udc;
    bit tk  = run && (m_psc == 0);
    bit hit = tk && (m_cnt == cmp_val);
    bit capclr = m_ccp && (cap0 || cap1);
    bit cmpclr = m_ccmp && hit;
    bit clr = (ctl_wr && wdata[4]) || capclr || cmpclr;
    bit wr_ev = tk && !clr && !load_trig &&
                ((dir && m_cnt == 16'hFFFF) || (!dir && m_cnt == 16'h0000));
    logic [15:0] n_cnt = m_cnt;
    int n_psc = m_psc;
    if (clr) n_cnt = 16'h0;
    else if (load_trig) n_cnt = load_val;
    else if (tk) n_cnt = dir ? m_cnt + 16'd1 : m_cnt - 16'd1;
    if (capclr || cmpclr) n_psc = int'(div);
    else if (run) n_psc = (m_psc == 0) ? int'(div) : m_psc - 1;
    @(posedge clk);
    if (cap0) begin m_c0 = m_cnt; m_of0 = m_seen || wr_ev; m_seen = 0; end
    else m_seen = m_seen || wr_ev;
    if (cap1) m_c1 = m_cnt;
    m_irq = wr_ev || hit || cap0 || cap1;
    m_ovf = wr_ev;
    if (ctl_wr) begin m_en = wdata[7]; m_ccp = wdata[6]; m_ccmp = wdata[5]; m_udc = wdata[3]; end
    m_cnt = n_cnt;
    m_psc = n_psc;
    @(negedge clk);
    chk("R2/R3 counter", cnt_o, m_cnt);
    chk("R10 capture0", cap0_o, m_c0);
    chk("R10 capture1", cap1_o, m_c1);
    chk("R4/R11 control read", rdata, exp_rdata());
    chk("R12 irq", irq, m_irq);
    chk("R5 ovf_pulse", ovf_pulse, m_ovf);
    if (ovf_pulse) saw_ovf = 1;
    if (int'(cnt_o) > max_cnt) max_cnt = int'(cnt_o);
    ctl_wr = 0; load_trig = 0; cap0 = 0; cap1 = 0;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; wdata = v; step();
  endtask

  task automatic do_load(input logic [15:0] v);
    load_trig = 1; load_val = v; step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 control", rdata, 8'h00);
    chk("R1 counter", cnt_o, 0);
    chk("R1 capture0", cap0_o, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf_pulse, 0);

    // R10 load and capture while disabled
    do_load(16'h1234);
    chk("R10 load disabled", cnt_o, 16'h1234);
    cap0 = 1; step();
    chk("R10 capture disabled", cap0_o, 16'h1234);
    chk("R12 capture irq", irq, 1);

    // R2/R11 enable, up count, global gate
    wr_ctl(8'h88);
    run_n(10);
    chk("R11 running", rdata[0], 1);
    glb_en = 0; run_n(5);
    chk("R11 halted", rdata[0], 0);
    glb_en = 1;

    // R3 prescaler divide by 4
    div = 8'd3; run_n(20);
    div = 8'd0; run_n(6);

    // R5 up wrap, R9 flag
    saw_ovf = 0;
    do_load(16'hFFFD); run_n(5);
    chk("R5 up wrap seen", saw_ovf, 1);
    cap0 = 1; step();
    chk("R9 flag after wrap", rdata[1], 1);
    cap0 = 1; step();
    chk("R9 flag no wrap", rdata[1], 0);

    // R5 down wrap
    wr_ctl(8'h80);
    saw_ovf = 0;
    do_load(16'h0002); run_n(5);
    chk("R5 down wrap seen", saw_ovf, 1);

    // R4 hardware direction overrides software bit
    wr_ctl(8'h88);
    do_load(16'h0100);
    hwv = 1; hwup = 0; step();
    chk("R4 hw direction status", rdata[2], 0);
    chk("R4 hw down count", cnt_o, 16'h00FF);
    hwv = 0; run_n(2);

    // R6 clear on capture, channel 1
    wr_ctl(8'hC8); run_n(3);
    cap1 = 1; step();
    chk("R6 capture clear", cnt_o, 0);
    div = 8'd2; run_n(4);
    cap0 = 1; step();
    chk("R6 capture0 clear", cnt_o, 0);
    run_n(7);
    div = 8'd0;

    // R7 clear on compare
    wr_ctl(8'hA8); cmp_val = 16'd5;
    do_load(16'h0000);
    max_cnt = 0; run_n(20);
    chk("R7 compare limit", max_cnt, 5);

    // R8 clear bit
    cmp_val = 16'h8000;
    wr_ctl(8'h88); run_n(3);
    wr_ctl(8'h98);
    chk("R8 clear counter", cnt_o, 0);
    chk("R8 no irq", irq, 0);
    chk("R8 reads zero", rdata[4], 0);
    run_n(4);

    finished = 1;
    finish_run();
  end
endmodule